// File: doc/BRIEF.md
# Dual-Wiper Serial Command Decoder

This block is the serial front end of a two-channel digital potentiometer. A host talks to it over a four-wire SPI-style link (active-low chip select, serial clock, serial data in, serial data out). Each channel keeps one 6-bit wiper register, which sets the tap position, and four 6-bit stored registers that stand in for nonvolatile presets. A frame carries a header byte with a device-type code and a two-bit address, a command byte with an opcode, a stored-register selector and a channel selector, and, for data commands, a third byte whose low six bits are a wiper position.

The opcodes cover reads and writes of both register kinds, copies between a wiper and one of its stored registers for one channel or for both at once, and a status read. Any command that writes a stored register starts a timed write cycle. While that cycle runs, a write-in-progress flag is set and every command other than the status read is dropped. The serial pins are sampled by the system clock through synchronisers, so the serial clock must run several times slower than the system clock. The two wiper positions leave the block as parallel buses.

Top module: `pot_cmd_decoder`

## Requirements
- R1: A frame whose header byte is not 0101 00 followed by the two address bits equal to `addr_strap` changes no register and returns nothing on `spi_so`. A command byte with bit 1 set to 1 is also dropped.
- R2: Command byte `{1010,xx,0,P}` followed by a data byte loads the low six data bits into wiper P (P=0 drives `wiper0`, P=1 drives `wiper1`). Command byte `{1001,xx,0,P}` returns `{00, wiper P}` on `spi_so` during the third byte.
- R3: Command byte `{1100,R,0,P}` with a data byte writes stored register R of channel P. Command byte `{1011,R,0,P}` returns `{00, that register}` in the third byte. The eight stored registers are independent.
- R4: Command byte `{1101,R,0,P}` copies stored register R of channel P into wiper P and leaves the other channel unchanged.
- R5: Command byte `{1110,R,0,P}` copies wiper P into stored register R of channel P.
- R6: Command byte `{0001,R,00}` copies stored register R of each channel into that channel's wiper. Command byte `{1000,R,00}` copies each wiper into stored register R of its own channel.
- R7: Command byte 0101 0001 returns a byte whose bit 0 is the write-in-progress flag and whose other bits are 0. The flag rises after chip select goes high on a completed stored-register write, single wiper-to-stored copy or global wiper-to-stored copy, and it stays set for exactly `NV_CYCLES` clock cycles.
- R8: While the write-in-progress flag is set, every command except the status read is ignored.
- R9: A frame that ends before all its bytes arrive (16 bits for copies, 24 bits for writes) changes no register and starts no write cycle.
- R10: Mode 0 timing: `spi_si` is taken on rising `spi_sck` and `spi_so` changes after falling `spi_sck`, MSB first. `spi_so` is high-impedance while chip select is high and is driven low during a frame whenever no read data is being sent.
- R11: After reset both wipers, all stored registers and the write-in-progress flag are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 2 | Address this device answers to |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_si | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial data to host, high-impedance when deselected |
| wiper0 | output | 6 | Wiper position of channel 0 |
| wiper1 | output | 6 | Wiper position of channel 1 |

## Verification
The hardest case to reach is a command that arrives while a write cycle is still running. That needs a full stored-register write, then a second frame inside the busy window, and it can only be observed later through a read once the window has closed. The bench sets a long write cycle, sends a wiper write and a status read right after a stored-register write, checks that the status shows busy and that the wiper did not move, then waits out the cycle and reads again. Truncated frames are produced by stopping the serial clock one bit short of each frame length before chip select rises.

// File: rtl/pot_pkg.sv
package pot_pkg;

  typedef enum logic [3:0] {
    OP_G_DR2WCR = 4'b0001,
    OP_STATUS   = 4'b0101,
    OP_G_WCR2DR = 4'b1000,
    OP_RD_WCR   = 4'b1001,
    OP_WR_WCR   = 4'b1010,
    OP_RD_DR    = 4'b1011,
    OP_WR_DR    = 4'b1100,
    OP_DR2WCR   = 4'b1101,
    OP_WCR2DR   = 4'b1110
  } opcode_e;

  typedef enum logic [2:0] {
    RF_NOP,
    RF_WR_WCR,
    RF_WR_DR,
    RF_DR2WCR,
    RF_WCR2DR,
    RF_G_DR2WCR,
    RF_G_WCR2DR
  } rf_op_e;

  localparam logic [3:0] DEV_TYPE   = 4'b0101;
  localparam logic [7:0] STATUS_CMD = 8'h51;

endpackage

// File: rtl/pot_pin_sync.sv
module pot_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pot_regfile.sv
module pot_regfile
  import pot_pkg::*;
#(
  parameter int W = 6,
  parameter int NDR = 4,
  localparam int SEL_W = $clog2(NDR)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  rf_op_e                op,
  input  logic                  ch,
  input  logic [SEL_W-1:0]      sel,
  input  logic [W-1:0]          wdata,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic [1:0][W-1:0]     wcr_o,
  output logic [1:0][W-1:0]     dr_rd_o
);
  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [W-1:0] dr_q [NDR];
    logic [W-1:0] wcr_q;
    logic         hit;

    assign hit = (ch == 1'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        wcr_q <= '0;
        for (int i = 0; i < NDR; i++) dr_q[i] <= '0;
      end else begin
        case (op)
          RF_WR_WCR:   if (hit) wcr_q <= wdata;
          RF_WR_DR:    if (hit) dr_q[sel] <= wdata;
          RF_DR2WCR:   if (hit) wcr_q <= dr_q[sel];
          RF_WCR2DR:   if (hit) dr_q[sel] <= wcr_q;
          RF_G_DR2WCR: wcr_q <= dr_q[sel];
          RF_G_WCR2DR: dr_q[sel] <= wcr_q;
          default: ;
        endcase
      end
    end

    assign wcr_o[c]   = wcr_q;
    assign dr_rd_o[c] = dr_q[rd_sel];
  end
endmodule

// File: rtl/pot_nv_timer.sv
module pot_nv_timer #(
  parameter int CYCLES = 2000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/pot_cmd_decoder.sv
module pot_cmd_decoder
  import pot_pkg::*;
#(
  parameter int WIPER_W = 6,
  parameter int NV_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         addr_strap,
  input  logic               spi_cs_n,
  input  logic               spi_sck,
  input  logic               spi_si,
  output logic               spi_so,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1
);
  localparam int NDR   = 4;
  localparam int SEL_W = $clog2(NDR);
  localparam int PAD   = 8 - WIPER_W;
  localparam logic [4:0] LEN_COPY  = 5'd16;
  localparam logic [4:0] LEN_WRITE = 5'd24;

  // pin synchronisation and edge detection
  logic cs_s, sck_s, si_s, cs_d, sck_d;
  logic cs_fall, cs_rise, sck_rise, sck_fall;

  pot_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk), .rst (rst),
    .din ({spi_cs_n, spi_sck, spi_si}),
    .dout({cs_s, sck_s, si_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_fall  = cs_d & ~cs_s;
  assign cs_rise  = ~cs_d & cs_s;
  assign sck_rise = ~sck_d & sck_s & ~cs_s;
  assign sck_fall = sck_d & ~sck_s & ~cs_s;

  // frame state
  logic [6:0]         shift_q;
  logic [7:0]         nb;
  logic [4:0]         bit_cnt_q;
  logic [7:0]         hdr_q, cmd_q;
  logic [WIPER_W-1:0] dat_q;
  logic [7:0]         out_sr_q;
  logic               reading_q, so_q, so_oe_q;

  // register file command
  rf_op_e             rf_op_q;
  logic               rf_ch_q;
  logic [SEL_W-1:0]   rf_sel_q;
  logic [WIPER_W-1:0] rf_data_q;
  logic               nv_start_q, nv_busy;
  logic [1:0][WIPER_W-1:0] wcr_all, dr_rd;

  assign nb = {shift_q, si_s};

  logic hdr_ok;
  assign hdr_ok = (hdr_q[7:4] == DEV_TYPE) && (hdr_q[3:2] == 2'b00) &&
                  (hdr_q[1:0] == addr_strap);

  // response byte for read commands, chosen when the command byte completes
  logic       resp_ok;
  logic [7:0] resp;
  always_comb begin
    resp_ok = 1'b0;
    resp    = '0;
    if (hdr_ok && !nb[1]) begin
      if (nb == STATUS_CMD) begin
        resp_ok = 1'b1;
        resp    = {7'b0, nv_busy};
      end else if (!nv_busy) begin
        case (opcode_e'(nb[7:4]))
          OP_RD_WCR: begin resp_ok = 1'b1; resp = {{PAD{1'b0}}, wcr_all[nb[0]]}; end
          OP_RD_DR:  begin resp_ok = 1'b1; resp = {{PAD{1'b0}}, dr_rd[nb[0]]};   end
          default: ;
        endcase
      end
    end
  end

  // command committed when chip select rises
  rf_op_e     cm_op;
  logic       cm_nv;
  logic [4:0] cm_need;
  always_comb begin
    cm_op   = RF_NOP;
    cm_nv   = 1'b0;
    cm_need = LEN_COPY;
    case (opcode_e'(cmd_q[7:4]))
      OP_WR_WCR:   begin cm_op = RF_WR_WCR;   cm_need = LEN_WRITE; end
      OP_WR_DR:    begin cm_op = RF_WR_DR;    cm_need = LEN_WRITE; cm_nv = 1'b1; end
      OP_DR2WCR:   cm_op = RF_DR2WCR;
      OP_WCR2DR:   begin cm_op = RF_WCR2DR;   cm_nv = 1'b1; end
      OP_G_DR2WCR: cm_op = RF_G_DR2WCR;
      OP_G_WCR2DR: begin cm_op = RF_G_WCR2DR; cm_nv = 1'b1; end
      default: ;
    endcase
  end

  logic cm_valid;
  assign cm_valid = hdr_ok && !cmd_q[1] && !nv_busy && (bit_cnt_q >= cm_need) &&
                    (cm_op != RF_NOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q    <= '0;
      bit_cnt_q  <= '0;
      hdr_q      <= '0;
      cmd_q      <= '0;
      dat_q      <= '0;
      out_sr_q   <= '0;
      reading_q  <= 1'b0;
      so_q       <= 1'b0;
      so_oe_q    <= 1'b0;
      rf_op_q    <= RF_NOP;
      rf_ch_q    <= 1'b0;
      rf_sel_q   <= '0;
      rf_data_q  <= '0;
      nv_start_q <= 1'b0;
    end else begin
      rf_op_q    <= RF_NOP;
      nv_start_q <= 1'b0;
      so_oe_q    <= ~cs_s;

      if (cs_fall) begin
        bit_cnt_q <= '0;
        reading_q <= 1'b0;
        so_q      <= 1'b0;
      end else if (sck_rise) begin
        shift_q <= nb[6:0];
        if (bit_cnt_q != 5'd31) bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == 5'd7)  hdr_q <= nb;
        if (bit_cnt_q == 5'd15) begin
          cmd_q <= nb;
          if (resp_ok) begin
            out_sr_q  <= resp;
            reading_q <= 1'b1;
          end
        end
        if (bit_cnt_q == 5'd23) dat_q <= nb[WIPER_W-1:0];
      end

      if (sck_fall && reading_q) begin
        so_q     <= out_sr_q[7];
        out_sr_q <= {out_sr_q[6:0], 1'b0};
      end

      if (cs_rise) begin
        reading_q <= 1'b0;
        so_q      <= 1'b0;
        if (cm_valid) begin
          rf_op_q    <= cm_op;
          rf_ch_q    <= cmd_q[0];
          rf_sel_q   <= cmd_q[3:2];
          rf_data_q  <= dat_q;
          nv_start_q <= cm_nv;
        end
      end
    end
  end

  pot_regfile #(.W(WIPER_W), .NDR(NDR)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .op     (rf_op_q),
    .ch     (rf_ch_q),
    .sel    (rf_sel_q),
    .wdata  (rf_data_q),
    .rd_sel (nb[3:2]),
    .wcr_o  (wcr_all),
    .dr_rd_o(dr_rd)
  );

  pot_nv_timer #(.CYCLES(NV_CYCLES)) u_nv (
    .clk  (clk),
    .rst  (rst),
    .start(nv_start_q),
    .busy (nv_busy)
  );

  assign wiper0 = wcr_all[0];
  assign wiper1 = wcr_all[1];
  assign spi_so = so_oe_q ? so_q : 1'bz;
endmodule

// File: rtl/pot_cmd_checker.sv
module pot_cmd_checker #(
  parameter int WIPER_W = 6,
  parameter int NV_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               cs_n,
  input logic [WIPER_W-1:0] wiper0,
  input logic [WIPER_W-1:0] wiper1,
  input logic               busy,
  input logic               nv_start,
  input logic               so_oe
);
  localparam int CW = $clog2(NV_CYCLES + 2);

  logic [CW-1:0] run_len;
  logic [3:0]    hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      hi_cnt  <= '0;
    end else begin
      run_len <= busy ? run_len + 1'b1 : '0;
      if (!cs_n)              hi_cnt <= '0;
      else if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  a_r11_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wiper0 == '0) && (wiper1 == '0) && !busy);

  a_r10_so_released: assert property (@(posedge clk) disable iff (rst)
    (int'(hi_cnt) >= SYNC_STAGES + 1) |-> !so_oe);

  a_r8_busy_freezes_wipers: assert property (@(posedge clk) disable iff (rst)
    $past(busy, 2) |-> $stable(wiper0) && $stable(wiper1));

  a_r7_start_sets_flag: assert property (@(posedge clk) disable iff (rst)
    nv_start |=> busy);

  a_r8_no_restart_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !nv_start);

  a_r7_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (int'(run_len) == NV_CYCLES));
endmodule

bind pot_cmd_decoder pot_cmd_checker #(
  .WIPER_W(WIPER_W), .NV_CYCLES(NV_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (spi_cs_n),
  .wiper0  (wiper0),
  .wiper1  (wiper1),
  .busy    (nv_busy),
  .nv_start(nv_start_q),
  .so_oe   (so_oe_q)
);

// File: tb/pot_cmd_decoder_tb_top.sv
module pot_cmd_decoder_tb_top;
  localparam int NV   = 2000;
  localparam int HALF = 6;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  wire  so;
  logic [5:0] w0, w1;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;
  pullup (so);

  pot_cmd_decoder #(.WIPER_W(6), .NV_CYCLES(NV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .addr_strap(STRAP),
    .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si), .spi_so(so),
    .wiper0(w0), .wiper1(w1)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input int nbits, output logic [7:0] rx);
    logic [23:0] word;
    word = {b0, b1, b2};
    rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      si = word[23-i];
      wait_clk(HALF);
      if (i >= 16) rx = {rx[6:0], so};
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  function automatic logic [7:0] hdr(logic [1:0] a);
    return {4'b0101, 2'b00, a};
  endfunction

  function automatic logic [7:0] cmd(logic [3:0] op, logic [1:0] r, logic p);
    return {op, r, 1'b0, p};
  endfunction

  task automatic wr_wcr(logic p, logic [5:0] v);
    logic [7:0] rx;
    xfer(hdr(STRAP), cmd(4'b1010, 2'b00, p), {2'b00, v}, 24, rx);
  endtask

  task automatic wr_dr(logic p, logic [1:0] r, logic [5:0] v);
    logic [7:0] rx;
    xfer(hdr(STRAP), cmd(4'b1100, r, p), {2'b00, v}, 24, rx);
  endtask

  task automatic rd_wcr(logic p, output logic [7:0] rx);
    xfer(hdr(STRAP), cmd(4'b1001, 2'b00, p), 8'h00, 24, rx);
  endtask

  task automatic rd_dr(logic p, logic [1:0] r, output logic [7:0] rx);
    xfer(hdr(STRAP), cmd(4'b1011, r, p), 8'h00, 24, rx);
  endtask

  task automatic rd_status(output logic [7:0] rx);
    xfer(hdr(STRAP), 8'h51, 8'h00, 24, rx);
  endtask

  task automatic copy(logic [3:0] op, logic [1:0] r, logic p);
    logic [7:0] rx;
    xfer(hdr(STRAP), cmd(op, r, p), 8'h00, 16, rx);
  endtask

  task automatic wait_nv();
    wait_clk(NV + 100);
  endtask

  task automatic t_reset();
    logic [7:0] rx;
    chk("R11 wiper0 after reset", {2'b0, w0}, 8'h00);
    chk("R11 wiper1 after reset", {2'b0, w1}, 8'h00);
    chk("R10 so released while deselected", {7'b0, so}, 8'h01);
    rd_status(rx);
    chk("R11 status after reset", rx, 8'h00);
    rd_dr(1'b0, 2'd3, rx);
    chk("R11 stored register after reset", rx, 8'h00);
  endtask

  task automatic t_wiper_rw();
    logic [7:0] rx;
    wr_wcr(1'b0, 6'h2A);
    wr_wcr(1'b1, 6'h15);
    chk("R2 wiper0 written", {2'b0, w0}, 8'h2A);
    chk("R2 wiper1 written", {2'b0, w1}, 8'h15);
    rd_wcr(1'b0, rx);
    chk("R2 R10 read wiper0 on so", rx, 8'h2A);
    rd_wcr(1'b1, rx);
    chk("R2 R10 read wiper1 on so", rx, 8'h15);
  endtask

  task automatic t_addr();
    logic [7:0] rx;
    xfer(hdr(2'b01), cmd(4'b1010, 2'b00, 1'b0), 8'h07, 24, rx);
    chk("R1 wrong address ignored", {2'b0, w0}, 8'h2A);
    xfer({4'b0110, 2'b00, STRAP}, cmd(4'b1010, 2'b00, 1'b1), 8'h07, 24, rx);
    chk("R1 wrong type ignored", {2'b0, w1}, 8'h15);
    xfer(hdr(STRAP), {4'b1010, 2'b00, 1'b1, 1'b0}, 8'h07, 24, rx);
    chk("R1 P1 set ignored", {2'b0, w0}, 8'h2A);
    xfer(hdr(2'b11), cmd(4'b1001, 2'b00, 1'b0), 8'h00, 24, rx);
    chk("R1 no read data for other address", rx, 8'h00);
  endtask

  task automatic t_stored();
    logic [7:0] rx;
    wr_dr(1'b1, 2'd2, 6'h11);
    rd_status(rx);
    chk("R7 flag set after stored write", rx, 8'h01);
    wait_nv();
    rd_status(rx);
    chk("R7 flag clear after cycle", rx, 8'h00);
    rd_dr(1'b1, 2'd2, rx);
    chk("R3 read stored ch1 r2", rx, 8'h11);
    rd_dr(1'b1, 2'd1, rx);
    chk("R3 neighbour register untouched", rx, 8'h00);
    rd_dr(1'b0, 2'd2, rx);
    chk("R3 other channel untouched", rx, 8'h00);
  endtask

  task automatic t_busy();
    logic [7:0] rx;
    wr_dr(1'b0, 2'd3, 6'h05);
    wr_wcr(1'b0, 6'h07);
    chk("R8 wiper write ignored while busy", {2'b0, w0}, 8'h2A);
    rd_status(rx);
    chk("R8 status still answered while busy", rx, 8'h01);
    wait_nv();
    chk("R8 wiper still unchanged after cycle", {2'b0, w0}, 8'h2A);
    rd_dr(1'b0, 2'd3, rx);
    chk("R3 stored ch0 r3", rx, 8'h05);
  endtask

  task automatic t_copy();
    logic [7:0] rx;
    copy(4'b1101, 2'd2, 1'b1);
    chk("R4 stored to wiper1", {2'b0, w1}, 8'h11);
    chk("R4 wiper0 untouched", {2'b0, w0}, 8'h2A);
    copy(4'b1110, 2'd0, 1'b0);
    rd_status(rx);
    chk("R7 flag set after single copy to stored", rx, 8'h01);
    wait_nv();
    rd_dr(1'b0, 2'd0, rx);
    chk("R5 wiper0 copied to stored r0", rx, 8'h2A);
  endtask

  task automatic t_global();
    logic [7:0] rx;
    wr_dr(1'b0, 2'd1, 6'h09);
    wait_nv();
    wr_dr(1'b1, 2'd1, 6'h30);
    wait_nv();
    copy(4'b0001, 2'd1, 1'b0);
    chk("R6 global stored to wiper0", {2'b0, w0}, 8'h09);
    chk("R6 global stored to wiper1", {2'b0, w1}, 8'h30);
    wr_wcr(1'b0, 6'h3C);
    wr_wcr(1'b1, 6'h01);
    copy(4'b1000, 2'd3, 1'b0);
    rd_status(rx);
    chk("R7 flag set after global copy to stored", rx, 8'h01);
    wait_nv();
    rd_dr(1'b0, 2'd3, rx);
    chk("R6 global wiper0 to stored r3", rx, 8'h3C);
    rd_dr(1'b1, 2'd3, rx);
    chk("R6 global wiper1 to stored r3", rx, 8'h01);
  endtask

  task automatic t_trunc();
    logic [7:0] rx;
    xfer(hdr(STRAP), cmd(4'b1010, 2'b00, 1'b0), 8'h15, 23, rx);
    chk("R9 short wiper write dropped", {2'b0, w0}, 8'h3C);
    xfer(hdr(STRAP), cmd(4'b1100, 2'd0, 1'b1), 8'h22, 23, rx);
    rd_status(rx);
    chk("R9 short stored write starts no cycle", rx, 8'h00);
    rd_dr(1'b1, 2'd0, rx);
    chk("R9 short stored write dropped", rx, 8'h00);
    xfer(hdr(STRAP), cmd(4'b1101, 2'd1, 1'b1), 8'h00, 15, rx);
    chk("R9 short copy dropped", {2'b0, w1}, 8'h01);
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(10);
    chk("R10 so driven low inside frame", {7'b0, so}, 8'h00);
    cs_n = 1'b1;
    wait_clk(10);
    chk("R10 so released after frame", {7'b0, so}, 8'h01);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_wiper_rw();
    t_addr();
    t_stored();
    t_busy();
    t_copy();
    t_global();
    t_trunc();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule